// File: doc/BRIEF.md
# AHB Read-Only Frame Fetch Engine

This block is a bus master that reads a frame of image data out of system memory and hands each 32-bit word to a downstream pixel FIFO. Software-side logic gives it a byte start address and a word count, then pulses a start input. The engine then requests the bus and issues read-only bursts until every word has arrived. It finishes with a one-cycle done pulse, or with a sticky error flag if a slave rejects a beat.

Each burst is sized from three limits: the words still to fetch, the free FIFO entries and the distance to the next 1 KB address boundary. A full 16-beat burst is used when all three allow it. A shorter run uses an undefined-length incrementing burst, and a lone word uses a single transfer. Address and data phases overlap by one cycle, and both freeze while the slave holds the ready line low.

Top module: `ahb_rd_dma`

## Requirements
- R1: Every active transfer is a read (`hwrite_o` = 0) of word size (`hsize_o` = 3'b010).
- R2: Burst length is L = min(words left to issue, `fifo_space_i`, words to the 1 KB boundary, 16). `hburst_o` is 3'b111 when L = 16, 3'b001 when 2 <= L <= 15, and 3'b000 when L = 1. L is fixed when the grant is taken. While `fifo_space_i` is 0, no bus request is raised.
- R3: No burst crosses a 1 KB address boundary; all beats of a burst share address bits [31:10].
- R4: The first beat of a burst has `htrans_o` = 2'b10, later beats 2'b11, and each beat's address is 4 above the previous one. Outside address phases, `htrans_o` = 2'b00.
- R5: A beat's data is taken from `hrdata_i` at the edge where its data phase sees `hready_i` high and `hresp_i` = 2'b00. It appears on `fifo_wdata_o` with `fifo_we_o` high for exactly the following cycle, in address order.
- R6: While `hready_i` is low with an OKAY response, address and transfer type are held on the next cycle.
- R7: `hbusreq_o` is high whenever an address phase is driven. No address phase is driven unless `hgrant_i` was high at the last edge with `hready_i` high.
- R8: A non-OKAY response (ERROR = 2'b01) during a data phase makes the next cycle idle. It also sets `err_o`, writes nothing for that beat, and gives no done pulse. `err_o` stays high until the next accepted start.
- R9: `done_o` pulses for one cycle, in the same cycle as the last FIFO write. For a word count of 0, it pulses in the cycle after start.
- R10: `start_i` is ignored while `busy_o` is high.
- R11: After reset, no request, no transfer, no FIFO write, and no done or error are signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a frame fetch |
| base_addr_i | input | 32 | Byte start address (word aligned) |
| word_cnt_i | input | CNT_W | Words to fetch |
| fifo_space_i | input | SPACE_W | Free entries in the downstream FIFO |
| hbusreq_o | output | 1 | Bus request |
| hgrant_i | input | 1 | Bus grant |
| haddr_o | output | 32 | Address |
| htrans_o | output | 2 | Transfer type |
| hwrite_o | output | 1 | Write strobe, always low |
| hsize_o | output | 3 | Transfer size |
| hburst_o | output | 3 | Burst type |
| hready_i | input | 1 | Transfer ready |
| hresp_i | input | 2 | Slave response |
| hrdata_i | input | 32 | Read data |
| fifo_we_o | output | 1 | FIFO write strobe |
| fifo_wdata_o | output | 32 | FIFO write data |
| busy_o | output | 1 | Fetch in progress |
| done_o | output | 1 | Frame complete pulse |
| err_o | output | 1 | Sticky abort flag |

## Verification
The hardest case to reach is an error arriving mid-burst while the next beat's address is already on the bus. The engine must drop that pending address, write nothing for the failed beat and leave the bus idle.

The bench's slave model counts beats and injects the two-cycle error response on a chosen beat index. Random wait states and grant delays run alongside it, so the abort lands with a live pipelined address. A start address 16 bytes below a 1 KB boundary, and a phase with zero FIFO space, steer the burst planner into its clipped and stalled cases.

// File: rtl/ahb_rd_dma_pkg.sv
package ahb_rd_dma_pkg;
  localparam logic [1:0] TR_IDLE   = 2'b00;
  localparam logic [1:0] TR_NONSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ    = 2'b11;

  localparam logic [2:0] BU_SINGLE = 3'b000;
  localparam logic [2:0] BU_INCR   = 3'b001;
  localparam logic [2:0] BU_INCR16 = 3'b111;

  localparam logic [2:0] SZ_WORD   = 3'b010;
  localparam logic [1:0] RSP_OKAY  = 2'b00;

  localparam int unsigned LEN_W    = 5;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_LAST
  } state_e;
endpackage

// File: rtl/ahb_rd_dma_plan.sv
module ahb_rd_dma_plan
  import ahb_rd_dma_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SPACE_W = 6
) (
  input  logic [7:0]         word_off_i,
  input  logic [CNT_W-1:0]   rem_i,
  input  logic [SPACE_W-1:0] space_i,
  output logic [LEN_W-1:0]   len_o,
  output logic [2:0]         burst_o
);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(16);

  function automatic logic [LEN_W-1:0] clamp(input logic [31:0] v);
    return (v >= 32'd16) ? MAX_LEN : v[LEN_W-1:0];
  endfunction

  logic [8:0]       to_bnd;
  logic [LEN_W-1:0] l_rem, l_spc, l_bnd, l_min;

  assign to_bnd = 9'd256 - {1'b0, word_off_i};

  always_comb begin
    l_rem = clamp(32'(rem_i));
    l_spc = clamp(32'(space_i));
    l_bnd = clamp(32'(to_bnd));
    l_min = l_rem;
    if (l_spc < l_min) l_min = l_spc;
    if (l_bnd < l_min) l_min = l_bnd;
    len_o = l_min;
    if (l_min == MAX_LEN)            burst_o = BU_INCR16;
    else if (l_min >= LEN_W'(2))     burst_o = BU_INCR;
    else                             burst_o = BU_SINGLE;
  end
endmodule

// File: rtl/ahb_rd_dma_dphase.sv
module ahb_rd_dma_dphase
  import ahb_rd_dma_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              hready_i,
  input  logic [1:0]        hresp_i,
  input  logic [DATA_W-1:0] hrdata_i,
  output logic              beat_done_o,
  output logic              err_hit_o,
  output logic              fifo_we_o,
  output logic [DATA_W-1:0] fifo_wdata_o
);
  logic pend_q;

  assign err_hit_o   = pend_q && (hresp_i != RSP_OKAY);
  assign beat_done_o = pend_q && hready_i && (hresp_i == RSP_OKAY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q       <= 1'b0;
      fifo_we_o    <= 1'b0;
      fifo_wdata_o <= '0;
    end else begin
      fifo_we_o <= beat_done_o;
      if (beat_done_o) fifo_wdata_o <= hrdata_i;
      if (err_hit_o)     pend_q <= 1'b0;
      else if (hready_i) pend_q <= accept_i;
    end
  end
endmodule

// File: rtl/ahb_rd_dma.sv
module ahb_rd_dma
  import ahb_rd_dma_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SPACE_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic [31:0]        base_addr_i,
  input  logic [CNT_W-1:0]   word_cnt_i,
  input  logic [SPACE_W-1:0] fifo_space_i,
  output logic               hbusreq_o,
  input  logic               hgrant_i,
  output logic [31:0]        haddr_o,
  output logic [1:0]         htrans_o,
  output logic               hwrite_o,
  output logic [2:0]         hsize_o,
  output logic [2:0]         hburst_o,
  input  logic               hready_i,
  input  logic [1:0]         hresp_i,
  input  logic [31:0]        hrdata_i,
  output logic               fifo_we_o,
  output logic [31:0]        fifo_wdata_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               err_o
);
  localparam int unsigned DATA_W = 32;

  state_e           state_q;
  logic [31:0]      addr_q;
  logic [CNT_W-1:0] iss_rem_q;
  logic [LEN_W-1:0] beats_q;
  logic             first_q;
  logic [2:0]       burst_q;
  logic             done_q, err_q;

  logic [LEN_W-1:0] plan_len;
  logic [2:0]       plan_burst;
  logic             beat_done, err_hit, accept;

  ahb_rd_dma_plan #(.CNT_W(CNT_W), .SPACE_W(SPACE_W)) u_plan (
    .word_off_i (addr_q[9:2]),
    .rem_i      (iss_rem_q),
    .space_i    (fifo_space_i),
    .len_o      (plan_len),
    .burst_o    (plan_burst)
  );

  assign accept = (state_q == ST_ADDR) && hready_i && !err_hit;

  ahb_rd_dma_dphase #(.DATA_W(DATA_W)) u_dphase (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .hready_i     (hready_i),
    .hresp_i      (hresp_i),
    .hrdata_i     (hrdata_i),
    .beat_done_o  (beat_done),
    .err_hit_o    (err_hit),
    .fifo_we_o    (fifo_we_o),
    .fifo_wdata_o (fifo_wdata_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      addr_q    <= '0;
      iss_rem_q <= '0;
      beats_q   <= '0;
      first_q   <= 1'b0;
      burst_q   <= BU_SINGLE;
      done_q    <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (err_hit) begin
        state_q <= ST_IDLE;
        err_q   <= 1'b1;
      end else begin
        unique case (state_q)
          ST_IDLE: if (start_i) begin
            addr_q    <= base_addr_i;
            iss_rem_q <= word_cnt_i;
            err_q     <= 1'b0;
            if (word_cnt_i == '0) done_q  <= 1'b1;
            else                  state_q <= ST_REQ;
          end
          ST_REQ: if (hgrant_i && hready_i && plan_len != '0) begin
            state_q <= ST_ADDR;
            beats_q <= plan_len;
            burst_q <= plan_burst;
            first_q <= 1'b1;
          end
          ST_ADDR: if (hready_i) begin
            addr_q    <= addr_q + 32'd4;
            iss_rem_q <= iss_rem_q - CNT_W'(1);
            beats_q   <= beats_q - LEN_W'(1);
            first_q   <= 1'b0;
            if (beats_q == LEN_W'(1)) state_q <= ST_LAST;
          end
          ST_LAST: if (beat_done) begin
            if (iss_rem_q == '0) begin
              done_q  <= 1'b1;
              state_q <= ST_IDLE;
            end else begin
              state_q <= ST_REQ;
            end
          end
          default: state_q <= ST_IDLE;
        endcase
      end
    end
  end

  assign htrans_o  = (state_q == ST_ADDR) ? (first_q ? TR_NONSEQ : TR_SEQ) : TR_IDLE;
  assign hbusreq_o = (state_q == ST_ADDR) || ((state_q == ST_REQ) && (fifo_space_i != '0));
  assign haddr_o   = addr_q;
  assign hburst_o  = burst_q;
  assign hwrite_o  = 1'b0;
  assign hsize_o   = SZ_WORD;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = done_q;
  assign err_o     = err_q;
endmodule

// File: rtl/ahb_rd_dma_chk.sv
module ahb_rd_dma_chk
  import ahb_rd_dma_pkg::*;
(
  input logic        clk_i,
  input logic        rst_ni,
  input logic        hbusreq_o,
  input logic        hgrant_i,
  input logic [31:0] haddr_o,
  input logic [1:0]  htrans_o,
  input logic        hwrite_o,
  input logic [2:0]  hsize_o,
  input logic [2:0]  hburst_o,
  input logic        hready_i,
  input logic [1:0]  hresp_i,
  input logic        fifo_we_o,
  input logic        busy_o,
  input logic        done_o,
  input logic        err_o
);
  logic        owner_q, dph_q;
  logic [31:0] acc_addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      owner_q    <= 1'b0;
      dph_q      <= 1'b0;
      acc_addr_q <= '0;
    end else if (hready_i) begin
      owner_q <= hgrant_i;
      dph_q   <= htrans_o[1];
      if (htrans_o[1]) acc_addr_q <= haddr_o;
    end
  end

  a_r1_read_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_o[1] |-> (!hwrite_o && hsize_o == SZ_WORD));

  a_r3_no_cross: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == TR_NONSEQ && hburst_o == BU_INCR16) |-> (haddr_o[9:2] <= 8'd240));

  a_r4_seq_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o == TR_SEQ) |-> (haddr_o == acc_addr_q + 32'd4));

  a_r5_write_after_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> ($past(hready_i) && $past(dph_q)));

  a_r6_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (htrans_o[1] && !hready_i && hresp_i == RSP_OKAY) |=>
      ($stable(haddr_o) && $stable(htrans_o) && $stable(hburst_o)));

  a_r7_owned_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
    htrans_o[1] |-> (owner_q && hbusreq_o));

  a_r8_err_abort: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dph_q && hresp_i != RSP_OKAY) |=> (err_o && !busy_o && htrans_o == TR_IDLE));

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && !hbusreq_o && !err_o));
endmodule

bind ahb_rd_dma ahb_rd_dma_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .hbusreq_o (hbusreq_o),
  .hgrant_i  (hgrant_i),
  .haddr_o   (haddr_o),
  .htrans_o  (htrans_o),
  .hwrite_o  (hwrite_o),
  .hsize_o   (hsize_o),
  .hburst_o  (hburst_o),
  .hready_i  (hready_i),
  .hresp_i   (hresp_i),
  .fifo_we_o (fifo_we_o),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .err_o     (err_o)
);

// File: tb/ahb_rd_dma_test.sv
module ahb_rd_dma_test;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 16;
  localparam int SPACE_W    = 6;

  logic               clk_i = 1'b0;
  logic               rst_ni = 1'b0;
  logic               start_i = 1'b0;
  logic [31:0]        base_addr_i = '0;
  logic [CNT_W-1:0]   word_cnt_i = '0;
  logic [SPACE_W-1:0] fifo_space_i = '0;
  logic               hgrant_i = 1'b0;
  logic               hready_i = 1'b1;
  logic [1:0]         hresp_i = 2'b00;
  logic [31:0]        hrdata_i = '0;
  logic               hbusreq_o, hwrite_o, fifo_we_o, busy_o, done_o, err_o;
  logic [31:0]        haddr_o, fifo_wdata_o;
  logic [1:0]         htrans_o;
  logic [2:0]         hsize_o, hburst_o;

  ahb_rd_dma #(.CNT_W(CNT_W), .SPACE_W(SPACE_W)) uut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0, cyc = 0;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: run hung act=%0d exp<=150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  // reference model state
  logic [31:0] q[$];
  logic [31:0] m_addr, pend_addr, bbase, sv_addr;
  logic [1:0]  sv_tr;
  logic [2:0]  m_burst;
  logic [15:0] lfsr = 16'hACE1;
  int  m_rem, m_beats, words_out, beat_no, pend_idx, err_at, err_ph, exp_cnt;
  int  done_cnt, space_v;
  bit  pend, owner, aborted, done_seen, wait_en, gdel_en, stall_prev;

  function automatic logic [31:0] mem(input logic [31:0] a);
    return {a[15:0] ^ 16'h3C5A, ~a[15:0]};
  endfunction

  function automatic int exp_len(input logic [31:0] a, input int rem, input int sp);
    int l = 16;
    int b = 256 - int'(a[9:2]);
    if (rem < l) l = rem;
    if (sp < l) l = sp;
    if (b < l) l = b;
    return l;
  endfunction

  task automatic tick();
    int l;
    @(negedge clk_i);
    if (fifo_we_o) begin
      if (q.size() == 0) chk(1'b0, "R5", "unexpected fifo write", fifo_wdata_o, 0);
      else begin
        chk(fifo_wdata_o == q[0], "R5", "fifo data order", fifo_wdata_o, q[0]);
        void'(q.pop_front());
      end
      words_out++;
    end
    if (done_o) begin
      done_seen = 1; done_cnt++;
      chk(q.size() == 0 && words_out == exp_cnt && !aborted, "R9", "done after last word",
          words_out, exp_cnt);
    end
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    hresp_i = 2'b00;
    if (err_ph == 1) begin
      hready_i = 1'b1; hresp_i = 2'b01; err_ph = 2;
    end else if (pend && pend_idx == err_at && err_ph == 0) begin
      hready_i = 1'b0; hresp_i = 2'b01; err_ph = 1;
    end else begin
      hready_i = wait_en ? (lfsr[0] | lfsr[1]) : 1'b1;
    end
    hrdata_i = pend ? mem(pend_addr) : 32'h0;
    hgrant_i = hbusreq_o && (hgrant_i || !gdel_en || lfsr[2]);
    #1;
    if (stall_prev)
      chk(haddr_o == sv_addr && htrans_o == sv_tr, "R6", "held during wait", haddr_o, sv_addr);
    if (htrans_o != 2'b00) begin
      chk(owner && hbusreq_o, "R7", "address phase without grant/request", owner, 1);
      chk(!hwrite_o && hsize_o == 3'b010, "R1", "read word", {hwrite_o, hsize_o}, 3'b010);
      chk(!aborted, "R8", "activity after abort", htrans_o, 0);
    end
    stall_prev = htrans_o[1] && !hready_i && hresp_i == 2'b00;
    sv_addr = haddr_o; sv_tr = htrans_o;
    if (err_ph == 1) begin
      aborted = 1; pend = 0;
    end else if (hready_i) begin
      if (pend && hresp_i == 2'b00) q.push_back(mem(pend_addr));
      pend = 0;
      if (htrans_o[1]) begin
        chk(haddr_o == m_addr, "R4", "beat address", haddr_o, m_addr);
        if (htrans_o == 2'b10) begin
          chk(m_beats == 0, "R4", "NONSEQ inside burst", m_beats, 0);
          l = exp_len(m_addr, m_rem, space_v);
          m_beats = l; bbase = haddr_o;
          m_burst = (l == 16) ? 3'b111 : (l >= 2) ? 3'b001 : 3'b000;
          chk(hburst_o == m_burst, "R2", "burst type", hburst_o, m_burst);
        end else begin
          chk(m_beats > 0, "R4", "SEQ past burst end", m_beats, 1);
          chk(hburst_o == m_burst, "R2", "burst type held", hburst_o, m_burst);
        end
        chk(haddr_o[31:10] == bbase[31:10], "R3", "1KB boundary", haddr_o, bbase);
        m_beats--; m_addr += 4; m_rem--;
        pend = 1; pend_addr = haddr_o; pend_idx = beat_no; beat_no++;
      end
      owner = hgrant_i;
    end
  endtask

  task automatic run(input logic [31:0] base, input int cnt, input int space, input bit w,
                     input bit g, input int e_at, input int hold0, input bit poke);
    m_addr = base; m_rem = cnt; exp_cnt = cnt; m_beats = 0; q.delete();
    words_out = 0; beat_no = 0; err_at = e_at; err_ph = 0; aborted = 0;
    done_seen = 0; done_cnt = 0; pend = 0; wait_en = w; gdel_en = g;
    space_v = (hold0 > 0) ? 0 : space;
    fifo_space_i = SPACE_W'(space_v);
    base_addr_i = base; word_cnt_i = CNT_W'(cnt); start_i = 1'b1;
    tick();
    start_i = 1'b0;
    for (int i = 0; i < hold0; i++) begin
      tick();
      chk(!hbusreq_o && htrans_o == 2'b00, "R2", "no request with zero space", hbusreq_o, 0);
    end
    space_v = space; fifo_space_i = SPACE_W'(space);
    for (int i = 0; i < 4000; i++) begin
      if (done_seen || (e_at >= 0 && aborted)) break;
      if (poke && i == 10) begin
        chk(busy_o, "R10", "busy before ignored start", busy_o, 1);
        start_i = 1'b1; base_addr_i = 32'h9000; word_cnt_i = CNT_W'(7);
      end
      tick();
      start_i = 1'b0;
    end
    repeat (4) tick();
    if (e_at < 0) begin
      chk(done_cnt == 1, "R9", "single done pulse", done_cnt, 1);
      chk(m_rem == 0 && m_beats == 0, "R2", "all bursts complete", m_rem, 0);
      chk(words_out == cnt, "R5", "word total", words_out, cnt);
      chk(!err_o && !busy_o, "R8", "no error flag on clean run", err_o, 0);
      if (poke) chk(words_out == cnt, "R10", "start during busy ignored", words_out, cnt);
    end else begin
      chk(aborted, "R8", "error injected", aborted, 1);
      chk(err_o && !busy_o, "R8", "sticky error, idle", err_o, 1);
      chk(words_out == e_at, "R8", "errored beat not written", words_out, e_at);
      chk(done_cnt == 0, "R8", "no done after abort", done_cnt, 0);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk(!hbusreq_o && htrans_o == 2'b00 && !fifo_we_o, "R11", "bus quiet after reset",
        {hbusreq_o, htrans_o, fifo_we_o}, 0);
    chk(!done_o && !err_o && !busy_o, "R11", "flags clear after reset", {done_o, err_o, busy_o}, 0);
    run(32'h0000_1000, 40, 63, 0, 0, -1, 0, 0);  // R2 INCR16 x2 + INCR8
    run(32'h0000_13F0, 20, 63, 1, 0, -1, 0, 0);  // R3 clipped to 4 then INCR16
    run(32'h0000_2000,  3,  1, 0, 1, -1, 0, 0);  // R2 SINGLE only
    run(32'h0000_3004, 12,  5, 1, 1, -1, 0, 0);  // R2 INCR by space, R6 waits
    run(32'h0000_4000,  1, 63, 1, 1, -1, 0, 0);
    run(32'h0000_4800,  0, 63, 0, 0, -1, 0, 0);  // R9 zero count
    run(32'h0000_5000,  6,  4, 1, 1, -1, 20, 0); // R2 zero space stall
    run(32'h0000_6000, 32, 63, 1, 1, 5, 0, 0);   // R8 abort on beat 5
    run(32'h0000_7FC0, 48, 63, 1, 1, -1, 0, 1);  // R8 flag cleared, R10 ignored start
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule